// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes a memory device from the state just after supply and clock become stable to an idle, ready state. To do this it drives a fixed sequence of commands on the command/address pins: clock enable, the four command strobes, a row/column address bus and a two-bit bank address. Every interval between commands is a cycle count set by a parameter. The code words for the two mode registers arrive on input ports. The block forces the DLL-reset bit in the base code itself: it is set on the first base load and cleared on the final one.

The sequence is fixed. First comes a long NOP wait, with clock enable held low at the start of the wait. Then a precharge of all banks, the extended mode load, a base mode load that resets the DLL, a second precharge of all banks, two auto refreshes, and a final base mode load with the DLL-reset bit cleared. After the last mode-register spacing has elapsed, `init_done` rises. From then on, the core's command requests pass straight to the pins.

A separate counter starts at the DLL-reset load and raises `read_ok` after the DLL lock time. Until then, a READ request is replaced by a NOP, while other requests still pass.

FSM states and transitions:
- ST_PWR_WAIT leaves for ST_PRE_A when the power-up count runs out.
- The command states ST_PRE_A, ST_LMR_EXT, ST_LMR_DLL, ST_PRE_B, ST_REF_A, ST_REF_B and ST_LMR_FIN each last one cycle. Each moves to its wait state (ST_WAIT_RP_A, ST_WAIT_MRD_A, ST_WAIT_MRD_B, ST_WAIT_RP_B, ST_WAIT_RFC_A, ST_WAIT_RFC_B and ST_WAIT_MRD_C respectively).
- Each wait state moves on to the next command state when the interval timer reaches its last cycle.
- ST_WAIT_MRD_C leads to ST_READY, which holds until reset.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is released (cycle 0 is the first cycle with reset low), the command is NOP ({cs_n,ras_n,cas_n,we_n}=0111) for cycles 0 to T_PWR-1. `cke` is low for cycles 0 to T_CKE_LOW-1, and high from then on until the next reset.
- R2: In cycle T_PWR the command is PRECHARGE (0010), with only address bit 10 set and bank 00.
- R3: T_RP cycles after the first precharge, the block issues a LOAD MODE (0000) with bank = 01 (bit 0 set) and the address equal to `emr_code`.
- R4: T_MRD cycles after the extended load, the block issues a LOAD MODE with bank 00 and the address equal to `mr_code` with bit 8 forced to 1.
- R5: T_MRD cycles later comes a second PRECHARGE with address bit 10 set. T_RP cycles after it comes AUTO REFRESH (0001). T_RFC cycles later comes a second AUTO REFRESH. T_RFC cycles after that comes a LOAD MODE with bank 00 and the address equal to `mr_code` with bit 8 forced to 0.
- R6: During initialization, every command lasts exactly one cycle. Every cycle that is not a command cycle carries NOP with address 0 and bank 0.
- R7: `init_done` rises exactly T_MRD cycles after the final LOAD MODE and stays high until reset.
- R8: `read_ok` rises exactly T_DLL cycles after the DLL-reset LOAD MODE and stays high until reset, whatever the state of `init_done`.
- R9: While `init_done` is low, requests on the `req_*` inputs have no effect on the pins.
- R10: While `init_done` is high, a request with `req_valid`=1 appears on the pins in the same cycle, carrying its command, address and bank. With `req_valid`=0 the pins carry NOP, address 0 and bank 0.
- R11: A READ request (0101) made while `read_ok` is low is replaced by NOP with address 0 and bank 0.
- R12: While `rst` is high, `cke`, `init_done` and `read_ok` are low and the command is NOP. After release, the whole sequence restarts from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| emr_code | input | ADDR_W | Extended mode register code |
| mr_code | input | ADDR_W | Base mode register operating code (bit 8 is overridden) |
| req_valid | input | 1 | Core command request valid |
| req_cmd | input | 4 | Requested {cs_n,ras_n,cas_n,we_n} |
| req_addr | input | ADDR_W | Requested address |
| req_ba | input | 2 | Requested bank |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | 2 | Bank address |
| init_done | output | 1 | Initialization complete |
| read_ok | output | 1 | DLL lock time elapsed, READ allowed |

## Verification
The bench builds the block with T_PWR=40, T_CKE_LOW=10, T_RP=3, T_MRD=2, T_RFC=7 and T_DLL=200. With these values the whole sequence ends at cycle 66, and `read_ok` rises at cycle 245. This leaves a window of almost 180 cycles in which ACTIVE requests pass while READ requests are blocked. T_MRD=2 is the tightest spacing the interval timer accepts, so back-to-back mode loads are exercised at their limit. One run is cut off by reset partway through the sequence, so the restart is observed both after a completed sequence and after an interrupted one.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Command codes as {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_LMR  = 4'b0000;
    localparam logic [3:0] CMD_REF  = 4'b0001;
    localparam logic [3:0] CMD_PRE  = 4'b0010;
    localparam logic [3:0] CMD_ACT  = 4'b0011;
    localparam logic [3:0] CMD_READ = 4'b0101;
    localparam logic [3:0] CMD_NOP  = 4'b0111;

    localparam int BIT_ALLBANK = 10;
    localparam int BIT_DLLRST  = 8;

    localparam logic [1:0] BA_BASE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b01;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_PRE_A,
        ST_WAIT_RP_A,
        ST_LMR_EXT,
        ST_WAIT_MRD_A,
        ST_LMR_DLL,
        ST_WAIT_MRD_B,
        ST_PRE_B,
        ST_WAIT_RP_B,
        ST_REF_A,
        ST_WAIT_RFC_A,
        ST_REF_B,
        ST_WAIT_RFC_B,
        ST_LMR_FIN,
        ST_WAIT_MRD_C,
        ST_READY
    } init_state_e;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ddr_dll_lock.sv
module ddr_dll_lock #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic locked
);

    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= LW'(1);
            armed_q <= 1'b1;
        end else if (armed_q && (cnt_q != LW'(LOCK_CYC))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign locked = armed_q && (cnt_q == LW'(LOCK_CYC));

endmodule

// File: rtl/ddr_cmd_mux.sv
module ddr_cmd_mux
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              init_done,
    input  logic              read_ok,
    input  logic [3:0]        seq_cmd,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [1:0]        seq_ba,
    input  logic              req_valid,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_ba,
    output logic [3:0]        out_cmd,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_ba
);

    logic read_blocked;
    logic take_req;

    assign read_blocked = (req_cmd == CMD_READ) && !read_ok;
    assign take_req     = init_done && req_valid && !read_blocked;

    always_comb begin
        if (!init_done) begin
            out_cmd  = seq_cmd;
            out_addr = seq_addr;
            out_ba   = seq_ba;
        end else if (take_req) begin
            out_cmd  = req_cmd;
            out_addr = req_addr;
            out_ba   = req_ba;
        end else begin
            out_cmd  = CMD_NOP;
            out_addr = '0;
            out_ba   = '0;
        end
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int T_PWR     = 20000,
    parameter int T_CKE_LOW = 100,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 8,
    parameter int T_DLL     = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] emr_code,
    input  logic [ADDR_W-1:0] mr_code,
    input  logic              req_valid,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_ba,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba,
    output logic              init_done,
    output logic              read_ok
);

    localparam int MAX_A = (T_PWR > T_RP) ? T_PWR : T_RP;
    localparam int MAX_B = (T_MRD > T_RFC) ? T_MRD : T_RFC;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);

    localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_MRD  = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] LD_RFC  = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] CKE_THR = CNT_W'(T_PWR - T_CKE_LOW);

    init_state_e state, state_nx;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_last;
    logic              dll_start;
    logic              dll_locked;
    logic              ready_st;
    logic [3:0]        seq_cmd;
    logic [ADDR_W-1:0] seq_addr;
    logic [1:0]        seq_ba;
    logic [3:0]        mux_cmd;
    logic [ADDR_W-1:0] mux_addr;
    logic [1:0]        mux_ba;
    logic              cke_int;

    ddr_init_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (T_PWR)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_cnt),
        .last     (tmr_last)
    );

    ddr_dll_lock #(
        .LOCK_CYC (T_DLL)
    ) u_lock (
        .clk    (clk),
        .rst    (rst),
        .start  (dll_start),
        .locked (dll_locked)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PWR_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWR_WAIT:   if (tmr_last) state_nx = ST_PRE_A;
            ST_PRE_A:      state_nx = ST_WAIT_RP_A;
            ST_WAIT_RP_A:  if (tmr_last) state_nx = ST_LMR_EXT;
            ST_LMR_EXT:    state_nx = ST_WAIT_MRD_A;
            ST_WAIT_MRD_A: if (tmr_last) state_nx = ST_LMR_DLL;
            ST_LMR_DLL:    state_nx = ST_WAIT_MRD_B;
            ST_WAIT_MRD_B: if (tmr_last) state_nx = ST_PRE_B;
            ST_PRE_B:      state_nx = ST_WAIT_RP_B;
            ST_WAIT_RP_B:  if (tmr_last) state_nx = ST_REF_A;
            ST_REF_A:      state_nx = ST_WAIT_RFC_A;
            ST_WAIT_RFC_A: if (tmr_last) state_nx = ST_REF_B;
            ST_REF_B:      state_nx = ST_WAIT_RFC_B;
            ST_WAIT_RFC_B: if (tmr_last) state_nx = ST_LMR_FIN;
            ST_LMR_FIN:    state_nx = ST_WAIT_MRD_C;
            ST_WAIT_MRD_C: if (tmr_last) state_nx = ST_READY;
            ST_READY:      state_nx = ST_READY;
            default:       state_nx = ST_PWR_WAIT;
        endcase
    end

    // Per-state outputs
    always_comb begin
        seq_cmd   = CMD_NOP;
        seq_addr  = '0;
        seq_ba    = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        dll_start = 1'b0;
        unique case (state)
            ST_PRE_A, ST_PRE_B: begin
                seq_cmd               = CMD_PRE;
                seq_addr[BIT_ALLBANK] = 1'b1;
                tmr_load              = 1'b1;
                tmr_val               = LD_RP;
            end
            ST_LMR_EXT: begin
                seq_cmd  = CMD_LMR;
                seq_addr = emr_code;
                seq_ba   = BA_EXT;
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
            end
            ST_LMR_DLL: begin
                seq_cmd              = CMD_LMR;
                seq_addr             = mr_code;
                seq_addr[BIT_DLLRST] = 1'b1;
                seq_ba               = BA_BASE;
                tmr_load             = 1'b1;
                tmr_val              = LD_MRD;
                dll_start            = 1'b1;
            end
            ST_REF_A, ST_REF_B: begin
                seq_cmd  = CMD_REF;
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
            end
            ST_LMR_FIN: begin
                seq_cmd              = CMD_LMR;
                seq_addr             = mr_code;
                seq_addr[BIT_DLLRST] = 1'b0;
                seq_ba               = BA_BASE;
                tmr_load             = 1'b1;
                tmr_val              = LD_MRD;
            end
            default: begin
                seq_cmd = CMD_NOP;
            end
        endcase
    end

    assign ready_st = (state == ST_READY);
    assign cke_int  = (state != ST_PWR_WAIT) || (tmr_cnt <= CKE_THR);

    ddr_cmd_mux #(
        .ADDR_W (ADDR_W)
    ) u_mux (
        .init_done (ready_st),
        .read_ok   (dll_locked),
        .seq_cmd   (seq_cmd),
        .seq_addr  (seq_addr),
        .seq_ba    (seq_ba),
        .req_valid (req_valid),
        .req_cmd   (req_cmd),
        .req_addr  (req_addr),
        .req_ba    (req_ba),
        .out_cmd   (mux_cmd),
        .out_addr  (mux_addr),
        .out_ba    (mux_ba)
    );

    // Pin drive, forced quiet during reset
    always_comb begin
        if (rst) begin
            cke                      = 1'b0;
            {cs_n, ras_n, cas_n, we_n} = CMD_NOP;
            addr                     = '0;
            ba                       = '0;
            init_done                = 1'b0;
            read_ok                  = 1'b0;
        end else begin
            cke                      = cke_int;
            {cs_n, ras_n, cas_n, we_n} = mux_cmd;
            addr                     = mux_addr;
            ba                       = mux_ba;
            init_done                = ready_st;
            read_ok                  = dll_locked;
        end
    end

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk
    import ddr_init_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic init_done,
    input logic read_ok
);

    logic [3:0] cmd;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    // R1
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R1
    nop_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd == CMD_NOP));

    // R6
    one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_done && (cmd != CMD_NOP)) |=> (cmd == CMD_NOP));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R8
    read_ok_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        read_ok |=> read_ok);

    // R9
    no_act_in_init_chk: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (cmd != CMD_ACT));

    // R11
    read_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !read_ok |-> (cmd != CMD_READ));

endmodule

bind ddr_init_seq ddr_init_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .init_done (init_done),
    .read_ok   (read_ok)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;

    localparam int AW    = 13;
    localparam int P_PWR = 40;
    localparam int P_CKL = 10;
    localparam int P_RP  = 3;
    localparam int P_MRD = 2;
    localparam int P_RFC = 7;
    localparam int P_DLL = 200;

    localparam int T_PRE1 = P_PWR;
    localparam int T_EMR  = T_PRE1 + P_RP;
    localparam int T_DLLM = T_EMR + P_MRD;
    localparam int T_PRE2 = T_DLLM + P_MRD;
    localparam int T_REF1 = T_PRE2 + P_RP;
    localparam int T_REF2 = T_REF1 + P_RFC;
    localparam int T_FIN  = T_REF2 + P_RFC;
    localparam int T_DONE = T_FIN + P_MRD;
    localparam int T_ROK  = T_DLLM + P_DLL;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;

    typedef struct {
        int          t;
        logic [3:0]  c;
        logic [12:0] a;
        logic [1:0]  b;
        string       tag;
    } ev_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] emr_code = '0;
    logic [AW-1:0] mr_code = '0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_cmd = 4'b0111;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_ba = '0;
    logic          cke, cs_n, ras_n, cas_n, we_n, init_done, read_ok;
    logic [AW-1:0] addr;
    logic [1:0]    ba;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;
    ev_t sched[$];

    always #5 clk = ~clk;

    ddr_init_seq #(
        .ADDR_W (AW), .T_PWR (P_PWR), .T_CKE_LOW (P_CKL), .T_RP (P_RP),
        .T_MRD (P_MRD), .T_RFC (P_RFC), .T_DLL (P_DLL)
    ) u0 (
        .clk (clk), .rst (rst), .emr_code (emr_code), .mr_code (mr_code),
        .req_valid (req_valid), .req_cmd (req_cmd), .req_addr (req_addr),
        .req_ba (req_ba), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .addr (addr), .ba (ba),
        .init_done (init_done), .read_ok (read_ok)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic build_sched(input logic [12:0] emr, input logic [12:0] mr);
        ev_t e;
        sched.delete();
        e.t = T_PRE1; e.c = C_PRE; e.a = 13'h0400; e.b = 2'b00; e.tag = "R2"; sched.push_back(e);
        e.t = T_EMR;  e.c = C_LMR; e.a = emr;      e.b = 2'b01; e.tag = "R3"; sched.push_back(e);
        e.t = T_DLLM; e.c = C_LMR; e.a = mr | 13'h0100; e.b = 2'b00; e.tag = "R4"; sched.push_back(e);
        e.t = T_PRE2; e.c = C_PRE; e.a = 13'h0400; e.b = 2'b00; e.tag = "R5"; sched.push_back(e);
        e.t = T_REF1; e.c = C_REF; e.a = 13'h0000; e.b = 2'b00; e.tag = "R5"; sched.push_back(e);
        e.t = T_REF2; e.c = C_REF; e.a = 13'h0000; e.b = 2'b00; e.tag = "R5"; sched.push_back(e);
        e.t = T_FIN;  e.c = C_LMR; e.a = mr & ~13'h0100; e.b = 2'b00; e.tag = "R5"; sched.push_back(e);
    endtask

    // Request pattern for cycle k: ACTIVE, READ, idle, repeating
    task automatic set_stim(input int k);
        case (k % 3)
            0: begin req_valid = 1'b1; req_cmd = C_ACT; end
            1: begin req_valid = 1'b1; req_cmd = C_RD;  end
            default: begin req_valid = 1'b0; req_cmd = C_ACT; end
        endcase
        req_addr = AW'(k * 37 + 5);
        req_ba   = 2'(k);
    endtask

    task automatic check_cycle(input int k);
        logic [3:0]  e_cmd = C_NOP;
        logic [12:0] e_addr = '0;
        logic [1:0]  e_ba = '0;
        string       tag = "R6";
        bit          hit = 0;
        bit          e_done = (k >= T_DONE);
        bit          e_rok = (k >= T_ROK);
        bit          e_cke = (k >= P_CKL);
        foreach (sched[i]) begin
            if (sched[i].t == k) begin
                e_cmd = sched[i].c; e_addr = sched[i].a; e_ba = sched[i].b;
                tag = sched[i].tag; hit = 1;
            end
        end
        if (!hit) begin
            if (e_done && req_valid && req_cmd == C_RD && !e_rok) tag = "R11";
            else if (e_done && req_valid) begin
                e_cmd = req_cmd; e_addr = req_addr; e_ba = req_ba; tag = "R10";
            end else if (e_done) tag = "R10";
            else if (k < P_PWR) tag = "R1";
            else if (req_valid) tag = "R9";
        end
        chk({cs_n, ras_n, cas_n, we_n} == e_cmd, tag, $sformatf("cmd@%0d", k),
            {cs_n, ras_n, cas_n, we_n}, e_cmd);
        chk(addr == e_addr, tag, $sformatf("addr@%0d", k), addr, e_addr);
        chk(ba == e_ba, tag, $sformatf("ba@%0d", k), ba, e_ba);
        chk(cke == e_cke, "R1", $sformatf("cke@%0d", k), cke, e_cke);
        chk(init_done == e_done, "R7", $sformatf("init_done@%0d", k), init_done, e_done);
        chk(read_ok == e_rok, "R8", $sformatf("read_ok@%0d", k), read_ok, e_rok);
    endtask

    // Called at a negedge with rst high; ends with rst high again
    task automatic run_pass(input int last_k, input logic [12:0] emr, input logic [12:0] mr);
        build_sched(emr, mr);
        emr_code = emr;
        mr_code  = mr;
        set_stim(0);
        rst = 1'b0;
        for (int k = 0; k <= last_k; k++) begin
            if (k > 0) @(negedge clk);
            check_cycle(k);
            set_stim(k + 1);
        end
        rst = 1'b1;
        for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            chk(cke == 1'b0, "R12", "cke in reset", cke, 0);
            chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R12", "cmd in reset",
                {cs_n, ras_n, cas_n, we_n}, C_NOP);
            chk(init_done == 1'b0, "R12", "init_done in reset", init_done, 0);
            chk(read_ok == 1'b0, "R12", "read_ok in reset", read_ok, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        run_pass(T_ROK + 15, 13'h0C05, 13'h1A31);
        run_pass(T_DLLM + 10, 13'h0003, 13'h0155);
        run_pass(T_ROK + 40, 13'h1FFE, 13'h0162);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule